// File: doc/BRIEF.md
# Oversampled UART Receiver with Error-Tagged Receive Queue

This block recovers asynchronous serial frames of eight data bits (least significant bit first), an optional parity bit and one stop bit from a single input line. It takes a sample tick at sixteen times the bit rate from an outside divider and resynchronises the line through a short flop chain. A start bit counts only if the line is still low halfway into the bit. Each frame is then sampled at the middle of each bit. Reception always runs to the stop bit, even when the parity or the stop bit turns out wrong.

A mode input chooses where finished frames go. In single mode they go to one holding word. In queue mode they go to a sixteen-entry first-in first-out store. Both hold the same 16-bit word: the data byte plus one flag for a parity error and one for a framing error. The block raises two one-cycle interrupt pulses. One marks a good reception. The other marks a faulty one: an error frame, an overrun of the holding word, or an overflow of the queue. A sticky three-bit status keeps the error kinds until software clears them with a write-one-to-clear strobe. Dropping the receive enable cancels any frame in flight without a trace and wipes the status.

Top module: `uart_rx_tagq`

## Requirements
- R1: In single mode with receive enable high, a frame with no parity or framing error is copied to the holding word, rxValid goes high and intEnd pulses for exactly one cycle.
- R2: In single mode, a frame that completes while rxValid is still high is dropped. The holding word keeps the earlier frame, intErr pulses instead of intEnd, and status bit 0 sets.
- R3: A frame with a parity error or a framing error (stop bit sampled low) still completes and is stored. intErr pulses instead of intEnd, and status bit 1 (parity) or bit 2 (framing) sets.
- R4: Clearing rxEnable during a frame abandons it. No interrupt pulses, the holding word is unchanged, and all status bits read 0.
- R5: While rxEnable is low, no frame is stored and intEnd never pulses.
- R6: In queue mode, intEnd pulses when an error-free frame is stored and the entry count after the store is at least the trigger level. A trigger level of 0, or one above the depth, acts as 1.
- R7: In queue mode, a frame that completes with the queue full is discarded. The count stays at the depth, status bit 0 sets and intErr pulses.
- R8: Every stored word has the data in bits 7:0, the parity error flag in bit 8, the framing error flag in bit 9, and zero in bits 15:10. The queue gives entries back in arrival order, with the oldest on rxWord.
- R9: A readStrobe in queue mode removes the oldest entry and lowers fifoCount by one. In single mode it lowers rxValid.
- R10: A one on a statusClr bit clears that status bit. Status bits whose statusClr bit is zero are left unchanged.
- R11: Any change of fifoMode empties the queue, so fifoCount reads 0.
- R12: intEnd and intErr are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| rxEnable | input | 1 | Receive enable. Low aborts and holds the receiver idle |
| fifoMode | input | 1 | 0 selects the holding word, 1 selects the queue |
| parityEn | input | 1 | Frame carries a parity bit |
| parityOdd | input | 1 | 1 selects odd parity, 0 selects even |
| trigLevel | input | 4 | Queue entry count at which intEnd fires |
| sampleTick | input | 1 | Oversampling tick, 16 per bit time |
| serialIn | input | 1 | Asynchronous serial line, idle high |
| readStrobe | input | 1 | Pops the queue or marks the holding word read |
| statusClr | input | 3 | Write-one-to-clear strobes for the status bits |
| rxWord | output | 16 | Holding word or oldest queue entry |
| rxValid | output | 1 | Unread data present |
| fifoCount | output | 5 | Number of queue entries |
| status | output | 3 | Sticky flags: bit 0 overrun/overflow, bit 1 parity, bit 2 framing |
| intEnd | output | 1 | Reception-end interrupt pulse |
| intErr | output | 1 | Reception-error interrupt pulse |

## Verification
With a tick on every clock, the stop bit is sampled about eleven cycles after the line enters the stop bit. The interrupt pulses, the stored word, rxValid, fifoCount and the status bits all change on the clock edge after that sample. Pulses are counted at falling edges, and frame results are read only after the whole stop bit plus an idle gap, so a result cannot be sampled too early. A pop, clear or mode change is applied at one falling edge and checked at the next, one rising edge later.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
  localparam int DATA_W = 8;
  localparam int WORD_W = 16;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PAR,
    ST_STOP
  } rxState_t;

  // strobes from the bit-timing control into the datapath
  typedef struct packed {
    logic shiftEn;
    logic parCap;
    logic frameDone;
  } rxStrobe_t;
endpackage

// File: rtl/rxq_control.sv
module rxq_control
  import rxq_pkg::*;
#(
  parameter int OVS = 16
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      rxEnable,
  input  logic      parityEn,
  input  logic      sampleTick,
  input  logic      rxLine,
  output rxStrobe_t strobe
);
  localparam int TickW = $clog2(OVS);
  localparam int BitW  = $clog2(DATA_W);
  localparam int Half  = OVS / 2;

  rxState_t   state;
  logic [TickW-1:0] tickCnt;
  logic [BitW-1:0]  bitCnt;
  logic       lastLine;
  logic       atBitEnd;
  logic       atHalf;
  logic       fallEdge;

  assign atBitEnd = sampleTick && (tickCnt == TickW'(OVS - 1));
  assign atHalf   = sampleTick && (tickCnt == TickW'(Half - 1));
  assign fallEdge = lastLine && !rxLine;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) lastLine <= 1'b1;
    else       lastLine <= rxLine;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      tickCnt <= '0;
      bitCnt  <= '0;
    end else if (!rxEnable) begin
      state   <= ST_IDLE;
      tickCnt <= '0;
      bitCnt  <= '0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          tickCnt <= '0;
          bitCnt  <= '0;
          if (fallEdge) state <= ST_START;
        end
        ST_START: begin
          if (atHalf) begin
            tickCnt <= '0;
            state   <= rxLine ? ST_IDLE : ST_DATA;
          end else if (sampleTick) begin
            tickCnt <= tickCnt + 1'b1;
          end
        end
        ST_DATA: begin
          if (atBitEnd) begin
            tickCnt <= '0;
            bitCnt  <= bitCnt + 1'b1;
            if (bitCnt == BitW'(DATA_W - 1)) state <= parityEn ? ST_PAR : ST_STOP;
          end else if (sampleTick) begin
            tickCnt <= tickCnt + 1'b1;
          end
        end
        ST_PAR: begin
          if (atBitEnd) begin
            tickCnt <= '0;
            state   <= ST_STOP;
          end else if (sampleTick) begin
            tickCnt <= tickCnt + 1'b1;
          end
        end
        ST_STOP: begin
          if (atBitEnd) begin
            tickCnt <= '0;
            state   <= ST_IDLE;
          end else if (sampleTick) begin
            tickCnt <= tickCnt + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    strobe.shiftEn   = rxEnable && (state == ST_DATA) && atBitEnd;
    strobe.parCap    = rxEnable && (state == ST_PAR)  && atBitEnd;
    strobe.frameDone = rxEnable && (state == ST_STOP) && atBitEnd;
  end
endmodule

// File: rtl/rxq_datapath.sv
module rxq_datapath
  import rxq_pkg::*;
#(
  parameter int DEPTH       = 16,
  parameter int SYNC_STAGES = 2,
  localparam int CntW       = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rxEnable,
  input  logic              fifoMode,
  input  logic              parityEn,
  input  logic              parityOdd,
  input  logic [3:0]        trigLevel,
  input  logic              serialIn,
  input  logic              readStrobe,
  input  logic [2:0]        statusClr,
  input  rxStrobe_t         strobe,
  output logic              rxLine,
  output logic [WORD_W-1:0] rxWord,
  output logic              rxValid,
  output logic [CntW-1:0]   fifoCount,
  output logic [2:0]        status,
  output logic              intEnd,
  output logic              intErr
);
  localparam int PtrW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  // input synchroniser
  logic [SYNC_STAGES-1:0] syncQ;
  generate
    if (SYNC_STAGES == 1) begin : gSync1
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncQ <= '1;
        else       syncQ <= serialIn;
      end
    end else begin : gSyncN
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncQ <= '1;
        else       syncQ <= {syncQ[SYNC_STAGES-2:0], serialIn};
      end
    end
  endgenerate
  assign rxLine = syncQ[SYNC_STAGES-1];

  // frame shifter and parity capture
  logic [DATA_W-1:0] shiftReg;
  logic              parBit;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
      parBit   <= 1'b0;
    end else begin
      if (strobe.shiftEn) shiftReg <= {rxLine, shiftReg[DATA_W-1:1]};
      if (strobe.parCap)  parBit   <= rxLine;
    end
  end

  logic              parErr, frmErr, anyErr;
  logic [WORD_W-1:0] newWord;
  always_comb begin
    parErr  = parityEn && (parBit != ((^shiftReg) ^ parityOdd));
    frmErr  = !rxLine;
    anyErr  = parErr || frmErr;
    newWord = {{(WORD_W - DATA_W - 2){1'b0}}, frmErr, parErr, shiftReg};
  end

  // holding word
  logic [WORD_W-1:0] holdWord;
  logic              holdFull;

  // queue storage
  logic [WORD_W-1:0] mem [DEPTH];
  logic [PtrW-1:0]   wrPtr, rdPtr;
  logic [CntW-1:0]   count;
  logic              modeQ;

  logic done, modeChg, fifoFull, pushOk, popOk, overflow, overrun, holdLoad;
  logic [CntW-1:0] newCount, trigEff;

  function automatic logic [PtrW-1:0] nextPtr(input logic [PtrW-1:0] p);
    return (p == PtrW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_comb begin
    done     = strobe.frameDone && rxEnable;
    modeChg  = fifoMode != modeQ;
    fifoFull = count == CntW'(DEPTH);
    pushOk   = done && fifoMode && !fifoFull && !modeChg;
    popOk    = readStrobe && fifoMode && (count != '0) && !modeChg;
    overflow = done && fifoMode && fifoFull;
    overrun  = done && !fifoMode && holdFull;
    holdLoad = done && !fifoMode && !holdFull;
    newCount = count + CntW'(pushOk) - CntW'(popOk);
    if (trigLevel == 4'd0 || int'(trigLevel) > DEPTH) trigEff = CntW'(1);
    else                                             trigEff = CntW'(trigLevel);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      holdWord <= '0;
      holdFull <= 1'b0;
    end else if (holdLoad) begin
      holdWord <= newWord;
      holdFull <= 1'b1;
    end else if (readStrobe && !fifoMode) begin
      holdFull <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (pushOk) mem[wrPtr] <= newWord;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
      modeQ <= 1'b0;
    end else begin
      modeQ <= fifoMode;
      if (modeChg) begin
        wrPtr <= '0;
        rdPtr <= '0;
        count <= '0;
      end else begin
        if (pushOk) wrPtr <= nextPtr(wrPtr);
        if (popOk)  rdPtr <= nextPtr(rdPtr);
        count <= newCount;
      end
    end
  end

  // interrupts and sticky status
  logic [2:0] setBits;
  always_comb begin
    setBits[0] = overrun || overflow;
    setBits[1] = done && parErr;
    setBits[2] = done && frmErr;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      intEnd <= 1'b0;
      intErr <= 1'b0;
      status <= '0;
    end else begin
      intEnd <= (holdLoad && !anyErr) ||
                (pushOk && !anyErr && (newCount >= trigEff));
      intErr <= overrun || overflow || (done && anyErr);
      if (!rxEnable) status <= '0;
      else           status <= (status & ~statusClr) | setBits;
    end
  end

  assign fifoCount = count;
  assign rxValid   = fifoMode ? (count != '0) : holdFull;
  assign rxWord    = fifoMode ? ((count != '0) ? mem[rdPtr] : '0) : holdWord;
endmodule

// File: rtl/uart_rx_tagq.sv
module uart_rx_tagq
  import rxq_pkg::*;
#(
  parameter int DEPTH       = 16,
  parameter int OVS         = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        rxEnable,
  input  logic        fifoMode,
  input  logic        parityEn,
  input  logic        parityOdd,
  input  logic [3:0]  trigLevel,
  input  logic        sampleTick,
  input  logic        serialIn,
  input  logic        readStrobe,
  input  logic [2:0]  statusClr,
  output logic [15:0] rxWord,
  output logic        rxValid,
  output logic [4:0]  fifoCount,
  output logic [2:0]  status,
  output logic        intEnd,
  output logic        intErr
);
  localparam int CntW = $clog2(DEPTH + 1);

  rxStrobe_t       strobe;
  logic            rxLine;
  logic [CntW-1:0] countInt;

  rxq_control #(.OVS(OVS)) uCtl (
    .clk        (clk),
    .rstN       (rstN),
    .rxEnable   (rxEnable),
    .parityEn   (parityEn),
    .sampleTick (sampleTick),
    .rxLine     (rxLine),
    .strobe     (strobe)
  );

  rxq_datapath #(.DEPTH(DEPTH), .SYNC_STAGES(SYNC_STAGES)) uDp (
    .clk        (clk),
    .rstN       (rstN),
    .rxEnable   (rxEnable),
    .fifoMode   (fifoMode),
    .parityEn   (parityEn),
    .parityOdd  (parityOdd),
    .trigLevel  (trigLevel),
    .serialIn   (serialIn),
    .readStrobe (readStrobe),
    .statusClr  (statusClr),
    .strobe     (strobe),
    .rxLine     (rxLine),
    .rxWord     (rxWord),
    .rxValid    (rxValid),
    .fifoCount  (countInt),
    .status     (status),
    .intEnd     (intEnd),
    .intErr     (intErr)
  );

  assign fifoCount = 5'(countInt);
endmodule

// File: rtl/rxq_checker.sv
module rxq_checker #(
  parameter int DEPTH = 16
) (
  input logic       clk,
  input logic       rstN,
  input logic       rxEnable,
  input logic       fifoMode,
  input logic       readStrobe,
  input logic [4:0] fifoCount,
  input logic [2:0] status,
  input logic       intEnd,
  input logic       intErr
);
  AST_INT_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    !(intEnd && intErr)); // R12

  AST_END_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    intEnd |=> !intEnd); // R1

  AST_NO_END_DISABLED: assert property (@(posedge clk) disable iff (!rstN)
    !$past(rxEnable) |-> !intEnd); // R5

  AST_STATUS_WIPED: assert property (@(posedge clk) disable iff (!rstN)
    !$past(rxEnable) |-> (status == 3'b000)); // R4

  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    int'(fifoCount) <= DEPTH); // R7

  AST_FULL_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (int'(fifoCount) == DEPTH && fifoMode && !readStrobe && $stable(fifoMode))
      |=> (int'(fifoCount) == DEPTH)); // R7

  AST_MODE_FLUSH: assert property (@(posedge clk) disable iff (!rstN)
    (fifoMode != $past(fifoMode)) |=> (fifoCount == 5'd0)); // R11
endmodule

bind uart_rx_tagq rxq_checker #(.DEPTH(DEPTH)) uChk (
  .clk        (clk),
  .rstN       (rstN),
  .rxEnable   (rxEnable),
  .fifoMode   (fifoMode),
  .readStrobe (readStrobe),
  .fifoCount  (fifoCount),
  .status     (status),
  .intEnd     (intEnd),
  .intErr     (intErr)
);

// File: tb/sim_uart_rx_tagq.sv
module sim_uart_rx_tagq;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        rxEnable = 1'b0;
  logic        fifoMode = 1'b0;
  logic        parityEn = 1'b0;
  logic        parityOdd = 1'b0;
  logic [3:0]  trigLevel = 4'd1;
  logic        sampleTick = 1'b1;
  logic        serialIn = 1'b1;
  logic        readStrobe = 1'b0;
  logic [2:0]  statusClr = 3'b000;
  logic [15:0] rxWord;
  logic        rxValid;
  logic [4:0]  fifoCount;
  logic [2:0]  status;
  logic        intEnd;
  logic        intErr;

  int checks = 0;
  int errors = 0;
  int endCnt = 0;
  int errCnt = 0;
  int bothCnt = 0;
  bit done = 0;

  always #10 clk = ~clk;

  uart_rx_tagq u0 (
    .clk(clk), .rstN(rstN), .rxEnable(rxEnable), .fifoMode(fifoMode),
    .parityEn(parityEn), .parityOdd(parityOdd), .trigLevel(trigLevel),
    .sampleTick(sampleTick), .serialIn(serialIn), .readStrobe(readStrobe),
    .statusClr(statusClr), .rxWord(rxWord), .rxValid(rxValid),
    .fifoCount(fifoCount), .status(status), .intEnd(intEnd), .intErr(intErr)
  );

  always @(negedge clk) begin
    if (intEnd) endCnt++;
    if (intErr) errCnt++;
    if (intEnd && intErr) bothCnt++;
  end

  // data, parEn, parOdd, badPar, badStop, expected word
  typedef struct packed {
    logic [7:0]  data;
    logic        pEn;
    logic        pOdd;
    logic        badPar;
    logic        badStop;
    logic [15:0] expWord;
  } vec_t;

  localparam int NV = 6;
  localparam vec_t VECS [NV] = '{
    '{8'hA5, 1'b0, 1'b0, 1'b0, 1'b0, 16'h00A5},
    '{8'h3C, 1'b1, 1'b0, 1'b0, 1'b0, 16'h003C},
    '{8'h81, 1'b1, 1'b1, 1'b0, 1'b0, 16'h0081},
    '{8'h5A, 1'b1, 1'b0, 1'b1, 1'b0, 16'h015A},
    '{8'hFF, 1'b0, 1'b0, 1'b0, 1'b1, 16'h02FF},
    '{8'h00, 1'b1, 1'b1, 1'b1, 1'b1, 16'h0300}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic lineBit(input logic v);
    serialIn = v;
    repeat (16) @(negedge clk);
  endtask

  // full frame with parity from the current parityEn/parityOdd settings
  task automatic sendFrame(input logic [7:0] d, input logic badPar, input logic badStop);
    logic pb;
    endCnt = 0;
    errCnt = 0;
    pb = (parityOdd ? ~^d : ^d) ^ badPar;
    lineBit(1'b0);
    for (int i = 0; i < 8; i++) lineBit(d[i]);
    if (parityEn) lineBit(pb);
    lineBit(!badStop);
    serialIn = 1'b1;
    repeat (8) @(negedge clk);
  endtask

  task automatic pulseRead();
    readStrobe = 1'b1;
    @(negedge clk);
    readStrobe = 1'b0;
  endtask

  task automatic pulseClr(input logic [2:0] m);
    statusClr = m;
    @(negedge clk);
    statusClr = 3'b000;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // reset state
    chk("R1 reset rxWord", rxWord, 0);
    chk("R1 reset rxValid", rxValid, 0);
    chk("R9 reset fifoCount", fifoCount, 0);
    chk("R10 reset status", status, 0);
    chk("R12 reset interrupts", {intEnd, intErr}, 0);
    rstN = 1'b1;
    @(negedge clk);
    rxEnable = 1'b1;
    repeat (4) @(negedge clk);

    // vector walk in single mode
    for (int v = 0; v < NV; v++) begin
      parityEn = VECS[v].pEn;
      parityOdd = VECS[v].pOdd;
      @(negedge clk);
      sendFrame(VECS[v].data, VECS[v].badPar, VECS[v].badStop);
      if (VECS[v].badPar || VECS[v].badStop) begin
        chk("R3 error frame intErr", errCnt, 1);
        chk("R3 error frame no intEnd", endCnt, 0);
      end else begin
        chk("R1 intEnd pulse", endCnt, 1);
        chk("R1 no intErr", errCnt, 0);
      end
      chk("R8 stored word", rxWord, VECS[v].expWord);
      chk("R1 rxValid", rxValid, 1);
      chk("R3 status flags", status, {VECS[v].badStop, VECS[v].badPar, 1'b0});
      pulseRead();
      chk("R9 single read clears rxValid", rxValid, 0);
      pulseClr(3'b111);
      chk("R10 status cleared", status, 0);
    end

    // overrun
    parityEn = 1'b0;
    @(negedge clk);
    sendFrame(8'h11, 1'b0, 1'b0);
    chk("R1 first frame intEnd", endCnt, 1);
    sendFrame(8'h22, 1'b0, 1'b0);
    chk("R2 overrun intErr", errCnt, 1);
    chk("R2 overrun no intEnd", endCnt, 0);
    chk("R2 holding keeps old", rxWord, 16'h0011);
    chk("R2 overrun status", status, 3'b001);
    pulseClr(3'b010);
    chk("R10 unselected bit kept", status, 3'b001);
    pulseRead();

    // abort mid-frame; status currently 001
    endCnt = 0;
    errCnt = 0;
    lineBit(1'b0);
    lineBit(1'b1);
    lineBit(1'b0);
    rxEnable = 1'b0;
    for (int i = 0; i < 7; i++) lineBit(1'b1);
    serialIn = 1'b1;
    repeat (8) @(negedge clk);
    chk("R4 abort no intEnd", endCnt, 0);
    chk("R4 abort no intErr", errCnt, 0);
    chk("R4 abort status wiped", status, 0);
    chk("R4 abort holding kept", rxWord, 16'h0011);
    chk("R4 abort nothing stored", rxValid, 0);

    // disabled reception
    sendFrame(8'h77, 1'b0, 1'b0);
    chk("R5 disabled no intEnd", endCnt, 0);
    chk("R5 disabled nothing stored", rxValid, 0);
    chk("R5 disabled holding kept", rxWord, 16'h0011);
    rxEnable = 1'b1;
    repeat (4) @(negedge clk);

    // queue mode trigger
    fifoMode = 1'b1;
    trigLevel = 4'd3;
    parityEn = 1'b1;
    parityOdd = 1'b0;
    repeat (2) @(negedge clk);
    sendFrame(8'h10, 1'b0, 1'b0);
    chk("R6 below trigger no intEnd", endCnt, 0);
    chk("R9 count after 1", fifoCount, 1);
    sendFrame(8'h20, 1'b0, 1'b0);
    chk("R6 below trigger no intEnd", endCnt, 0);
    sendFrame(8'h30, 1'b0, 1'b0);
    chk("R6 trigger reached intEnd", endCnt, 1);
    chk("R9 count after 3", fifoCount, 3);
    sendFrame(8'h40, 1'b1, 1'b0);
    chk("R3 queue error intErr", errCnt, 1);
    chk("R3 queue error no intEnd", endCnt, 0);
    chk("R9 count after 4", fifoCount, 4);
    pulseClr(3'b111);

    // arrival order and tags
    chk("R8 head first", rxWord, 16'h0010);
    pulseRead();
    chk("R8 head second", rxWord, 16'h0020);
    chk("R9 pop decrements", fifoCount, 3);
    pulseRead();
    chk("R8 head third", rxWord, 16'h0030);
    pulseRead();
    chk("R8 parity tag in queue", rxWord, 16'h0140);
    pulseRead();
    chk("R9 queue empty", fifoCount, 0);
    chk("R9 rxValid low when empty", rxValid, 0);

    // trigger 0 acts as 1, then fill to full
    trigLevel = 4'd0;
    parityEn = 1'b0;
    @(negedge clk);
    sendFrame(8'h01, 1'b0, 1'b0);
    chk("R6 trigger zero acts as one", endCnt, 1);
    for (int k = 2; k <= 16; k++) sendFrame(8'(k), 1'b0, 1'b0);
    chk("R7 queue full count", fifoCount, 16);
    sendFrame(8'h99, 1'b0, 1'b0);
    chk("R7 overflow intErr", errCnt, 1);
    chk("R7 overflow no intEnd", endCnt, 0);
    chk("R7 count stays at depth", fifoCount, 16);
    chk("R7 overflow status", status, 3'b001);
    chk("R7 head unchanged", rxWord, 16'h0001);
    pulseClr(3'b001);
    chk("R10 overflow cleared", status, 0);

    // mode change flush
    fifoMode = 1'b0;
    @(negedge clk);
    @(negedge clk);
    fifoMode = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk("R11 flush count", fifoCount, 0);
    chk("R11 flush rxValid", rxValid, 0);

    chk("R12 never both interrupts", bothCnt, 0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog R1 actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule